// File: doc/BRIEF.md
# Dual-Mode I/Q Sample Assembler

This block sits at the front of a quadrature upconverter. It collects baseband in-phase (I) and quadrature (Q) samples from one of two input formats and passes each complete pair to the signal chain. A static mode input selects the format. In word mode, I and Q words take turns on a single 16-bit bus. In bit mode, I and Q arrive on two separate one-bit lanes, and each lane carries one bit per data-clock tick.

The block makes its own data-clock enable, `dclk_en`. This is a one-cycle strobe on the system clock that repeats every `DCLK_DIV` cycles. A configuration input can turn the strobe off, and the bench keeps it on by default. Each capture happens on a system clock edge where `dclk_en` is high. The transmit-enable input `tx_en` frames every burst. Its rising edge, as seen on a strobe, aligns the first I word or bit 0 of both serial lanes. While `tx_en` is low the inputs are ignored and the outputs are forced to zero. A burst that ends part-way through a pair or a frame raises an error flag.

The controller is a four-state machine. `ST_IDLE` waits for the rise of enable. The `go_par` transition captures I and moves to `ST_PAR_Q`. The `go_ser` transition shifts bit 0 and moves to `ST_SER`. `ST_PAR_Q` takes Q and releases the pair (`pair_done`), then moves to `ST_PAR_I`. `ST_PAR_I` takes the next I and moves back to `ST_PAR_Q`. `ST_SER` shifts one bit per strobe and releases the pair on bit 15 (`frame_done`). From every active state, the `stop` transition on a strobe with enable low returns to `ST_IDLE`.

Top module: `iq_capture_top`

## Requirements
- R1: With `cfg_dclk_on` high, `dclk_en` is high for exactly one system cycle in every `DCLK_DIV` (default 2). With `cfg_dclk_on` low, `dclk_en` stays low.
- R2: After synchronous reset, `out_i`, `out_q`, `out_valid` and `proto_err` are all 0.
- R3: In word mode (`cfg_serial`=0), the first strobe with `tx_en` high after a strobe with it low captures `par_data` as I. The next strobe captures Q. One cycle after the Q strobe, `out_i`/`out_q` show that pair.
- R4: `out_valid` is high for exactly one cycle per completed pair. Between pairs, `out_i`/`out_q` hold the last pair, even across an I capture.
- R5: From the cycle after any strobe with `tx_en` low, `out_i` and `out_q` are 0, `out_valid` is 0, and the input bus and lanes have no effect.
- R6: In bit mode (`cfg_serial`=1), the first strobe with enable high takes bit 15 (MSB) of both words from `ser_i`/`ser_q`. Each later strobe takes the next lower bit. The pair is released one cycle after the 16th strobe, and never earlier.
- R7: In bit mode, frames follow back to back while `tx_en` stays high. Each group of 16 strobes forms a new pair.
- R8: In word mode, if enable falls after an I with no Q, `proto_err` goes to 1 and no pair is released. The flag stays set until the next rise of enable, which clears it. A fall after an even count leaves it at 0.
- R9: In bit mode, if enable falls after a strobe count that is not a multiple of 16, `proto_err` goes to 1 and the partial frame is discarded. A fall on a multiple of 16 leaves `proto_err` at 0.
- R10: While `cfg_dclk_on` is low, nothing is captured and no pair is released, even with enable high and the inputs changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_serial | input | 1 | Static mode: 0 word-interleaved, 1 dual serial lane |
| cfg_dclk_on | input | 1 | Turns the data-clock strobe on |
| tx_en | input | 1 | Transmit enable; frames capture bursts |
| par_data | input | 16 | Word-mode input bus |
| ser_i | input | 1 | Bit-mode I lane |
| ser_q | input | 1 | Bit-mode Q lane |
| dclk_en | output | 1 | Data-clock strobe that paces the source |
| out_i | output | 16 | Assembled I sample |
| out_q | output | 16 | Assembled Q sample |
| out_valid | output | 1 | One-cycle strobe per completed pair |
| proto_err | output | 1 | Burst ended mid pair or mid frame |

## Verification
The bench runs bursts of every length from one to five words, and serial bursts of 1, 15, 16, 17 and 32 bits. A design that counts parity wrongly would flag clean bursts or miss short ones. One that counts bits wrongly would release frames a bit early or late. Serial words such as 0x8000 and 0x0001 put a single set bit at each end of the word, so a reversed shift order shows up at once. Between pairs the bench checks that the outputs do not change when an I word arrives, which catches a design that updates I on its own. It also stops the strobe while enable is high and the inputs change; a design that captured without the strobe would release stray pairs.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAR_I,
        ST_PAR_Q,
        ST_SER
    } cap_state_e;
endpackage

// File: rtl/iq_dclk_gen.sv
module iq_dclk_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic on,
    output logic strobe
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !on) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign strobe = on && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // strobe never lasts two cycles when the divide ratio exceeds one
            p_strobe_spacing_r1: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);
        end
    endgenerate
endmodule

// File: rtl/iq_lane_shift.sv
module iq_lane_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] word_next
);
    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (shift) begin
            word_q <= word_next;
        end
    end

    // most significant bit arrives first, so new bits enter at the bottom
    assign word_next = {word_q[W-2:0], bit_in};
endmodule

// File: rtl/iq_capture_fsm.sv
module iq_capture_fsm
    import iq_cap_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic         serial_mode,
    input  logic         tx_en,
    input  logic [W-1:0] par_data,
    input  logic [W-1:0] ser_i_next,
    input  logic [W-1:0] ser_q_next,
    output logic         shift_en,
    output logic [W-1:0] out_i,
    output logic [W-1:0] out_q,
    output logic         out_valid,
    output logic         proto_err
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(W - 1);

    cap_state_e state, nxt;
    logic             tx_prev;
    logic             rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     i_hold;

    assign rise = tx_en && !tx_prev;
    assign shift_en = strobe && tx_en && serial_mode &&
                      ((state == ST_SER) || (state == ST_IDLE && rise));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (strobe && rise) nxt = serial_mode ? ST_SER : ST_PAR_Q;
            ST_PAR_I: if (strobe) nxt = tx_en ? ST_PAR_Q : ST_IDLE;
            ST_PAR_Q: if (strobe) nxt = tx_en ? ST_PAR_I : ST_IDLE;
            ST_SER:   if (strobe && !tx_en) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tx_prev <= 1'b0;
        end else begin
            state <= nxt;
            if (strobe) tx_prev <= tx_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
            proto_err <= 1'b0;
            bit_cnt   <= '0;
            i_hold    <= '0;
        end else begin
            out_valid <= 1'b0;
            if (strobe) begin
                if (!tx_en) begin
                    out_i   <= '0;
                    out_q   <= '0;
                    bit_cnt <= '0;
                    if (state == ST_PAR_Q || (state == ST_SER && bit_cnt != '0))
                        proto_err <= 1'b1;
                end else begin
                    unique case (state)
                        ST_IDLE: begin
                            if (rise) begin
                                proto_err <= 1'b0;
                                if (serial_mode) bit_cnt <= CNT_W'(1);
                                else             i_hold  <= par_data;
                            end
                        end
                        ST_PAR_I: i_hold <= par_data;
                        ST_PAR_Q: begin
                            out_i     <= i_hold;
                            out_q     <= par_data;
                            out_valid <= 1'b1;
                        end
                        ST_SER: begin
                            if (bit_cnt == BIT_LAST) begin
                                out_i     <= ser_i_next;
                                out_q     <= ser_q_next;
                                out_valid <= 1'b1;
                                bit_cnt   <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_valid_after_enabled_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(strobe) && $past(tx_en)));

    p_zero_when_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(strobe) && !$past(tx_en)) |-> (out_i == '0 && out_q == '0 && !out_valid));

    p_err_excludes_valid_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !out_valid);

    p_serial_frame_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && serial_mode) |-> (bit_cnt == '0));
endmodule

// File: rtl/iq_capture_top.sv
module iq_capture_top
    import iq_cap_pkg::*;
#(
    parameter int W        = WORD_W,
    parameter int DCLK_DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_serial,
    input  logic         cfg_dclk_on,
    input  logic         tx_en,
    input  logic [W-1:0] par_data,
    input  logic         ser_i,
    input  logic         ser_q,
    output logic         dclk_en,
    output logic [W-1:0] out_i,
    output logic [W-1:0] out_q,
    output logic         out_valid,
    output logic         proto_err
);
    localparam int LANES = 2;

    logic             shift_en;
    logic [LANES-1:0] lane_bit;
    logic [W-1:0]     lane_word [LANES];

    assign lane_bit = {ser_q, ser_i};

    iq_dclk_gen #(.DIV(DCLK_DIV)) u_dclk (
        .clk    (clk),
        .rst    (rst),
        .on     (cfg_dclk_on),
        .strobe (dclk_en)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            iq_lane_shift #(.W(W)) u_lane (
                .clk       (clk),
                .rst       (rst),
                .shift     (shift_en),
                .bit_in    (lane_bit[g]),
                .word_next (lane_word[g])
            );
        end
    endgenerate

    iq_capture_fsm #(.W(W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .strobe      (dclk_en),
        .serial_mode (cfg_serial),
        .tx_en       (tx_en),
        .par_data    (par_data),
        .ser_i_next  (lane_word[0]),
        .ser_q_next  (lane_word[1]),
        .shift_en    (shift_en),
        .out_i       (out_i),
        .out_q       (out_q),
        .out_valid   (out_valid),
        .proto_err   (proto_err)
    );

    p_no_capture_without_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(dclk_en) |-> (!out_valid && $stable(out_i) && $stable(out_q)));
endmodule

// File: tb/iq_capture_top_bench.sv
module iq_capture_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_serial = 1'b0;
    logic        cfg_dclk_on = 1'b1;
    logic        tx_en = 1'b0;
    logic [15:0] par_data = '0;
    logic        ser_i = 1'b0;
    logic        ser_q = 1'b0;
    logic        dclk_en;
    logic [15:0] out_i, out_q;
    logic        out_valid, proto_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    iq_capture_top u_iq_capture_top (
        .clk(clk), .rst(rst), .cfg_serial(cfg_serial), .cfg_dclk_on(cfg_dclk_on),
        .tx_en(tx_en), .par_data(par_data), .ser_i(ser_i), .ser_q(ser_q),
        .dclk_en(dclk_en), .out_i(out_i), .out_q(out_q),
        .out_valid(out_valid), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one capture strobe, then sample at the following falling edge
    task automatic step(input logic t, input logic [15:0] pd, input logic si,
                        input logic sq);
        while (dclk_en !== 1'b1) @(negedge clk);
        tx_en = t; par_data = pd; ser_i = si; ser_q = sq;
        @(negedge clk);
    endtask

    task automatic idle_step();
        step(1'b0, 16'hDEAD, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] pi, pq, wi, wq;
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        chk(out_i == 0 && out_q == 0, "R2 outputs", {out_i, out_q}, 0);
        chk(!out_valid && !proto_err, "R2 flags", {out_valid, proto_err}, 0);

        // R1 strobe rate
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (dclk_en) cnt++;
        end
        chk(cnt == 10, "R1 strobe count", cnt, 10);
        cfg_dclk_on = 1'b0;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (dclk_en) cnt++;
        end
        chk(cnt == 0, "R1 strobe off", cnt, 0);
        cfg_dclk_on = 1'b1;

        // R3 R4 word-mode sweep
        idle_step();
        pi = 0; pq = 0;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] ni, nq;
            ni = 16'(k * 16'h1357) ^ 16'hA5A5;
            nq = ~ni + 16'(k);
            step(1'b1, ni, 1'b0, 1'b0);
            chk(!out_valid, "R4 no valid on I", out_valid, 0);
            chk(out_i == pi && out_q == pq, "R4 hold on I", {out_i, out_q}, {pi, pq});
            step(1'b1, nq, 1'b0, 1'b0);
            chk(out_valid, "R3 valid on Q", out_valid, 1);
            chk(out_i == ni && out_q == nq, "R3 pair", {out_i, out_q}, {ni, nq});
            pi = ni; pq = nq;
            @(negedge clk);
            chk(!out_valid, "R4 single pulse", out_valid, 0);
        end

        // R10 strobe disabled mid-burst
        cfg_dclk_on = 1'b0;
        for (int k = 0; k < 20; k++) begin
            tx_en = 1'b1; par_data = 16'(k * 77);
            @(negedge clk);
            chk(!out_valid && out_i == pi && out_q == pq, "R10 frozen",
                {out_i, out_q}, {pi, pq});
        end
        cfg_dclk_on = 1'b1;
        step(1'b1, 16'h0F0F, 1'b0, 1'b0);
        step(1'b1, 16'hF0F0, 1'b0, 1'b0);
        chk(out_valid && out_i == 16'h0F0F && out_q == 16'hF0F0, "R10 resume",
            {out_i, out_q}, {16'h0F0F, 16'hF0F0});

        // R5 enable low ignores input
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 16'(16'h1111 * k), k[0], k[1]);
            chk(out_i == 0 && out_q == 0 && !out_valid, "R5 zeroed",
                {out_i, out_q}, 0);
            chk(!proto_err, "R8 clean stop", proto_err, 0);
        end

        // R8 burst length sweep in word mode
        for (int n = 1; n <= 5; n++) begin
            for (int k = 0; k < n; k++) begin
                step(1'b1, 16'(n * 16'h0101 + k), 1'b0, 1'b0);
                if (k == 0) chk(!proto_err, "R8 rise clears", proto_err, 0);
            end
            step(1'b0, 16'hBEEF, 1'b0, 1'b0);
            chk(proto_err == n[0], "R8 parity flag", proto_err, n[0]);
            chk(out_i == 0 && out_q == 0 && !out_valid, "R8 discard", {out_i, out_q}, 0);
            idle_step();
            chk(proto_err == n[0], "R8 flag held", proto_err, n[0]);
        end
        step(1'b1, 16'h1234, 1'b0, 1'b0);
        chk(!proto_err, "R8 rise clears", proto_err, 1'b0);
        idle_step();

        // R6 R7 serial frames, back to back
        cfg_serial = 1'b1;
        idle_step();
        pi = 0; pq = 0;
        for (int f = 0; f < 6; f++) begin
            case (f)
                0: begin wi = 16'h8000; wq = 16'h0001; end
                1: begin wi = 16'h0001; wq = 16'h8000; end
                2: begin wi = 16'hFFFF; wq = 16'h0000; end
                default: begin
                    wi = 16'(f * 16'h2B3D) ^ 16'h5A0F;
                    wq = ~16'(f * 16'h1F21);
                end
            endcase
            for (int b = 15; b >= 0; b--) begin
                step(1'b1, 16'hCAFE, wi[b], wq[b]);
                if (b != 0) begin
                    chk(!out_valid && out_i == pi && out_q == pq, "R6 no early release",
                        {out_i, out_q}, {pi, pq});
                end else begin
                    chk(out_valid, "R7 frame valid", out_valid, 1);
                    chk(out_i == wi && out_q == wq, "R6 serial pair",
                        {out_i, out_q}, {wi, wq});
                end
            end
            pi = wi; pq = wq;
        end
        idle_step();
        chk(!proto_err && out_i == 0, "R9 clean frame stop", {proto_err, out_i}, 0);

        // R9 serial length sweep
        for (int s = 0; s < 5; s++) begin
            int len;
            bit bad;
            case (s)
                0: len = 1;
                1: len = 15;
                2: len = 16;
                3: len = 17;
                default: len = 32;
            endcase
            bad = (len % 16) != 0;
            for (int k = 0; k < len; k++) begin
                step(1'b1, 16'h0, k[0], k[1]);
                if (k == 0) chk(!proto_err, "R9 rise clears", proto_err, 0);
            end
            step(1'b0, 16'h0, 1'b1, 1'b1);
            chk(proto_err == bad, "R9 frame flag", proto_err, bad);
            chk(!out_valid && out_i == 0 && out_q == 0, "R9 discard", {out_i, out_q}, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule